// File: doc/BRIEF.md
# SMBus Host Notify Slave Receiver

This block is the slave side of the SMBus Host Notify transfer. A faster system clock oversamples the SCL and SDA bus lines. The block recognises a write sent to a fixed host address. It collects the sender's 7-bit device address and a 16-bit data word. Once the frame has ended cleanly with a STOP, the block latches these values into holding registers and raises a sticky status flag, which also serves as the interrupt. The block only ever pulls SDA low, to acknowledge, through an open-drain enable output.

Software reads the captured address and data through a small register port. It then clears the flag by writing a one to it, and this re-enables acceptance of the next notification. While the flag is still set, a new notification is refused with a NACK at the address byte, and the earlier values stay in place. Once the address matches, the block assumes the master follows the protocol and does not look at the R/W bit.

Top module: `smb_notify_rx`

## Requirements
- R1: After reset, irq and sda_oe are 0, and all four readable registers return 0.
- R2: A first byte whose upper seven bits equal the host address 7'b0001000, received while the flag is clear, is acknowledged. SDA is held low by sda_oe=1 during the ninth clock of that byte, and sda_oe only rises while SCL is low.
- R3: Once the address matches, the R/W bit (bit 0 of the first byte) is ignored. A value of 1 still gives an ACK and a capture.
- R4: A first byte with any other address is never acknowledged in any slot, and it changes no register and not the flag.
- R5: After an accepted address, the next three bytes are each acknowledged. The register port returns these values: reg_addr 1 gives {1'b0, bits 7:1 of the second byte}, reg_addr 2 gives the third byte (data low), and reg_addr 3 gives the fourth byte (data high).
- R6: The flag (reg_addr 0 bit 0, also irq) is set only when a STOP follows the fourth byte's ACK. It stays 0 before that STOP.
- R7: While the flag is set, a matching address is not acknowledged, and the device and data registers keep their values.
- R8: A frame cut short by a STOP or a repeated START before its final STOP changes neither the registers nor the flag.
- R9: A write to reg_addr 0 with reg_wbit=1 clears the flag. A write with reg_wbit=0 leaves the flag unchanged.
- R10: If a clearing write and the STOP that completes a capture take effect in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired bus value) |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| reg_addr | input | 2 | Register select: 0 status, 1 device address, 2 data low, 3 data high |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_wbit | input | 1 | Write data; a 1 written to reg_addr 0 clears the flag |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| irq | output | 1 | Interrupt, equal to the status flag |

## Verification
The flag has two writers that can act in the same cycle: a capture that sets it on the closing STOP, and a software write-one that clears it. The bench counts the synchroniser stages from its own SDA rising edge. It places the clearing write on exactly the clock edge where the STOP is registered. It then requires the flag to read as set, with the captured values, on the following read. Random frames with early cuts and random clears also land clears next to captures, and the bench judges each result against its own register model.

// File: rtl/smbn_pkg.sv
package smbn_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 7;
  localparam int NUM_BYTES = 4;
  localparam int CNT_W     = $clog2(BYTE_W);
  localparam int IDX_W     = $clog2(NUM_BYTES);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACKW,
    ST_ACK,
    ST_DONE,
    ST_SKIP
  } smbn_state_e;
endpackage

// File: rtl/smbn_sync.sv
module smbn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_l,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [STAGES:0] scl_pipe;
  logic [STAGES:0] sda_pipe;
  logic            scl_d;
  logic            sda_d;

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
    end
  end

  assign scl_s = scl_pipe[STAGES-1];
  assign scl_d = scl_pipe[STAGES];
  assign sda_s = sda_pipe[STAGES-1];
  assign sda_d = sda_pipe[STAGES];

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smbn_fsm.sv
module smbn_fsm
  import smbn_pkg::*;
#(
  parameter logic [ADDR_W-1:0] HOST_ADDR = 7'b0001000
) (
  input  logic              clk,
  input  logic              rst_l,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic              status_i,
  output logic              sda_oe,
  output logic              commit,
  output logic [ADDR_W-1:0] dev_t,
  output logic [BYTE_W-1:0] lo_t,
  output logic [BYTE_W-1:0] hi_t
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BYTES - 1);

  smbn_state_e       st_q, st_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-2:0] sh_q, sh_n;
  logic              oe_q, oe_n;
  logic [ADDR_W-1:0] dev_q, dev_n;
  logic [BYTE_W-1:0] lo_q, lo_n, hi_q, hi_n;
  logic [BYTE_W-1:0] byte_w;

  assign byte_w = {sh_q, sda_s};

  always_comb begin
    st_n   = st_q;
    idx_n  = idx_q;
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    oe_n   = oe_q;
    dev_n  = dev_q;
    lo_n   = lo_q;
    hi_n   = hi_q;
    commit = 1'b0;
    if (start_p) begin
      st_n  = ST_RX;
      idx_n = '0;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else if (stop_p) begin
      commit = (st_q == ST_DONE);
      st_n   = ST_IDLE;
      oe_n   = 1'b0;
    end else begin
      case (st_q)
        ST_RX: if (scl_rise) begin
          sh_n  = byte_w[BYTE_W-2:0];
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) begin
            st_n = ST_ACKW;
            case (idx_q)
              IDX_W'(0): if (byte_w[BYTE_W-1:1] != HOST_ADDR || status_i) st_n = ST_SKIP;
              IDX_W'(1): dev_n = byte_w[BYTE_W-1:1];
              IDX_W'(2): lo_n  = byte_w;
              default:   hi_n  = byte_w;
            endcase
          end
        end
        ST_ACKW: if (scl_fall) begin
          st_n = ST_ACK;
          oe_n = 1'b1;
        end
        ST_ACK: if (scl_fall) begin
          oe_n  = 1'b0;
          cnt_n = '0;
          if (idx_q == LAST_IDX) begin
            st_n = ST_DONE;
          end else begin
            idx_n = idx_q + 1'b1;
            st_n  = ST_RX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      cnt_q <= '0;
      sh_q  <= '0;
      oe_q  <= 1'b0;
      dev_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else begin
      st_q  <= st_n;
      idx_q <= idx_n;
      cnt_q <= cnt_n;
      sh_q  <= sh_n;
      oe_q  <= oe_n;
      dev_q <= dev_n;
      lo_q  <= lo_n;
      hi_q  <= hi_n;
    end
  end

  assign sda_oe = oe_q;
  assign dev_t  = dev_q;
  assign lo_t   = lo_q;
  assign hi_t   = hi_q;

  // R2: the pull-down only starts while SCL is low
  a_r2_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_l)
    $rose(oe_q) |-> !scl_s);
  // R8: any STOP returns to idle with SDA released
  a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_l)
    stop_p |=> (st_q == ST_IDLE) && !oe_q);
endmodule

// File: rtl/smbn_regs.sv
module smbn_regs
  import smbn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_l,
  input  logic              commit,
  input  logic [ADDR_W-1:0] dev_t,
  input  logic [BYTE_W-1:0] lo_t,
  input  logic [BYTE_W-1:0] hi_t,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_wbit,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              status
);
  logic              st_q, st_n;
  logic [ADDR_W-1:0] dev_q, dev_n;
  logic [BYTE_W-1:0] lo_q, lo_n, hi_q, hi_n;
  logic              clr;

  assign clr = reg_wr && (reg_addr == 2'd0) && reg_wbit;

  always_comb begin
    dev_n = dev_q;
    lo_n  = lo_q;
    hi_n  = hi_q;
    st_n  = st_q;
    if (clr) st_n = 1'b0;
    if (commit) begin
      st_n  = 1'b1;
      dev_n = dev_t;
      lo_n  = lo_t;
      hi_n  = hi_t;
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      st_q  <= 1'b0;
      dev_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else begin
      st_q  <= st_n;
      dev_q <= dev_n;
      lo_q  <= lo_n;
      hi_q  <= hi_n;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {{(BYTE_W-1){1'b0}}, st_q};
      2'd1:    reg_rdata = {1'b0, dev_q};
      2'd2:    reg_rdata = lo_q;
      default: reg_rdata = hi_q;
    endcase
  end

  assign status = st_q;

  // R6: the flag only rises from a completed capture
  a_r6_set_by_commit: assert property (@(posedge clk) disable iff (!rst_l)
    $rose(st_q) |-> $past(commit));
  // R10: a capture wins over a same-cycle clear
  a_r10_capture_wins: assert property (@(posedge clk) disable iff (!rst_l)
    commit |=> st_q);
  // R7: held values are frozen while the flag is set
  a_r7_hold_values: assert property (@(posedge clk) disable iff (!rst_l)
    st_q |=> $stable(dev_q) && $stable(lo_q) && $stable(hi_q));
endmodule

// File: rtl/smb_notify_rx.sv
module smb_notify_rx
  import smbn_pkg::*;
#(
  parameter logic [ADDR_W-1:0] HOST_ADDR   = 7'b0001000,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_wbit,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              irq
);
  logic [1:0]        rst_pipe;
  logic              rst_l;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic              status, commit;
  logic [ADDR_W-1:0] dev_t;
  logic [BYTE_W-1:0] lo_t, hi_t;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_l = rst_pipe[1];

  smbn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_l(rst_l), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  smbn_fsm #(.HOST_ADDR(HOST_ADDR)) u_fsm (
    .clk(clk), .rst_l(rst_l), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p),
    .status_i(status), .sda_oe(sda_oe), .commit(commit),
    .dev_t(dev_t), .lo_t(lo_t), .hi_t(hi_t)
  );

  smbn_regs u_regs (
    .clk(clk), .rst_l(rst_l), .commit(commit),
    .dev_t(dev_t), .lo_t(lo_t), .hi_t(hi_t),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wbit(reg_wbit),
    .reg_rdata(reg_rdata), .status(status)
  );

  assign irq = status;
endmodule

// File: tb/tb_smb_notify_rx.sv
module tb_smb_notify_rx;
  localparam logic [6:0] HOST = 7'b0001000;
  localparam int Q = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       m_scl, m_sda;
  logic       sda_oe, irq;
  logic [1:0] reg_addr;
  logic       reg_wr, reg_wbit;
  logic [7:0] reg_rdata;
  wire        sda_bus = m_sda & ~sda_oe;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  bit         m_st;
  logic [6:0] m_dev;
  logic [7:0] m_lo, m_hi;

  always #10 clk = ~clk;

  smb_notify_rx dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wbit(reg_wbit),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired act=%0d exp<190000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic bit exp_accept(input logic [6:0] a, input bit st);
    return (a == HOST) && !st;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return {7'b0, m_st};
      2'd1:    return {1'b0, m_dev};
      2'd2:    return m_lo;
      default: return m_hi;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic verify_all(input string tag);
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check(tag, {24'b0, d}, {24'b0, exp_rd(2'(a))});
    end
    check(tag, {31'b0, irq}, {31'b0, m_st});
  endtask

  task automatic wr_status(input bit v);
    @(negedge clk);
    reg_addr = 2'd0;
    reg_wbit = v;
    reg_wr   = 1'b1;
    @(negedge clk);
    reg_wr   = 1'b0;
    if (v) m_st = 1'b0;
  endtask

  task automatic put_bit(input bit b);
    m_sda = b;
    hq();
    m_scl = 1'b1;
    hq();
    m_scl = 1'b0;
  endtask

  task automatic get_ack(output bit a);
    m_sda = 1'b1;
    hq();
    m_scl = 1'b1;
    repeat (Q / 2) @(negedge clk);
    a = sda_bus;
    repeat (Q - Q / 2) @(negedge clk);
    m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit a);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_ack(a);
  endtask

  task automatic go_start();
    m_sda = 1'b1;
    hq();
    m_scl = 1'b1;
    hq();
    m_sda = 1'b0;
    hq();
    m_scl = 1'b0;
  endtask

  task automatic go_stop(input bit collide);
    m_sda = 1'b0;
    hq();
    m_scl = 1'b1;
    hq();
    m_sda = 1'b1;
    if (collide) begin
      // STOP is seen after two sync stages; the clear lands on the same edge
      @(negedge clk);
      @(negedge clk);
      reg_addr = 2'd0;
      reg_wbit = 1'b1;
      reg_wr   = 1'b1;
      @(negedge clk);
      reg_wr   = 1'b0;
    end
    hq();
  endtask

  // cut: 0 full frame, 1 STOP after data low, 2 repeated START after device byte
  task automatic frame(input logic [6:0] ha, input bit rw, input logic [6:0] dv,
                       input logic [7:0] lo, input logic [7:0] hi, input int cut,
                       input bit collide);
    bit    a;
    bit    acc;
    string tg;
    acc = exp_accept(ha, m_st);
    tg  = (ha != HOST) ? "R4 address ack" : (m_st ? "R7 nack while set" :
          (rw ? "R3 rw ignored ack" : "R2 address ack"));
    go_start();
    send_byte({ha, rw}, a);
    check(tg, {31'b0, a}, {31'b0, !acc});
    send_byte({dv, 1'b0}, a);
    check(acc ? "R5 device ack" : "R4 no device ack", {31'b0, a}, {31'b0, !acc});
    if (cut == 2) begin
      go_start();
      go_stop(1'b0);
      return;
    end
    send_byte(lo, a);
    check(acc ? "R5 low ack" : "R4 no low ack", {31'b0, a}, {31'b0, !acc});
    if (cut == 1) begin
      go_stop(1'b0);
      return;
    end
    send_byte(hi, a);
    check(acc ? "R5 high ack" : "R4 no high ack", {31'b0, a}, {31'b0, !acc});
    check("R6 flag before stop", {31'b0, irq}, {31'b0, m_st});
    go_stop(collide);
    if (acc) begin
      m_st  = 1'b1;
      m_dev = dv;
      m_lo  = lo;
      m_hi  = hi;
    end
  endtask

  initial begin
    logic [6:0] ha;
    int         r;
    rst_n    = 1'b0;
    m_scl    = 1'b1;
    m_sda    = 1'b1;
    reg_addr = 2'd0;
    reg_wr   = 1'b0;
    reg_wbit = 1'b0;
    m_st     = 1'b0;
    m_dev    = '0;
    m_lo     = '0;
    m_hi     = '0;
    void'($urandom(32'd5150));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    check("R1 oe after reset", {31'b0, sda_oe}, 32'd0);
    verify_all("R1 reset state");

    frame(HOST, 1'b0, 7'h5A, 8'hC3, 8'h3C, 0, 1'b0);
    verify_all("R5 R6 capture");

    frame(HOST, 1'b0, 7'h11, 8'h22, 8'h33, 0, 1'b0);
    verify_all("R7 values kept");

    wr_status(1'b0);
    verify_all("R9 write zero");
    wr_status(1'b1);
    verify_all("R9 write one");

    frame(HOST, 1'b1, 7'h7F, 8'hFF, 8'h00, 0, 1'b0);
    verify_all("R3 capture with rw set");
    wr_status(1'b1);

    frame(HOST, 1'b0, 7'h01, 8'hAA, 8'h55, 1, 1'b0);
    verify_all("R8 stop cut");
    frame(HOST, 1'b0, 7'h02, 8'hAB, 8'hCD, 2, 1'b0);
    verify_all("R8 start cut");

    frame(7'b0001001, 1'b0, 7'h03, 8'h12, 8'h34, 0, 1'b0);
    verify_all("R4 other address");

    frame(HOST, 1'b0, 7'h44, 8'h9E, 8'h61, 0, 1'b1);
    verify_all("R10 capture beats clear");
    wr_status(1'b1);

    for (int n = 0; n < 30; n++) begin
      r  = int'($urandom % 5);
      ha = ($urandom % 4 != 0) ? HOST : 7'($urandom);
      if (ha == HOST && ($urandom % 4 == 0)) ha = HOST ^ 7'h40;
      frame(ha, 1'($urandom), 7'($urandom), 8'($urandom), 8'($urandom),
            (r < 3) ? 0 : r - 2, 1'b0);
      verify_all("R5 R8 random frame");
      if ($urandom % 2 == 0) begin
        wr_status(1'($urandom));
        verify_all("R9 random write");
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule